// File: doc/BRIEF.md
# Dual-Mode Video PHY Power Sequencer

This block brings a combined serial-video / LVDS transmitter PHY up and takes it down again. It does this by issuing a fixed list of masked register writes on a simple valid/acknowledge write port. Each write carries an 8-bit address, an 8-bit mask and an 8-bit value. Between some steps the sequencer waits for a set number of clock cycles, so that resets last long enough and supplies have time to settle. The analog circuits, PLL lock detection and the host bus sit outside the block.

A power-on request samples a 3-bit mode selector and the divider settings. It runs a common bandgap and power-work prefix, followed by either the serial-video bring-up or the LVDS bring-up. A power-off request runs a single teardown list that is the same for both modes. The block raises `done` for one cycle when a list finishes, or `error` for one cycle when it rejects a request. Each write address is a 3-bit register group followed by a 5-bit offset. Group 0 is analog, group 1 is digital and group 7 is LVDS.

Top module: `phy_pwr_seq`

## Requirements
- R1: `wr_addr` = {group[2:0], offset[4:0]}. While `wr_valid` is high and `wr_ack` is low, the next cycle keeps `wr_valid` high with address, mask and data unchanged. A write is accepted on an edge where both `wr_valid` and `wr_ack` are high.
- R2: Every power-on list starts with two writes as (addr, mask, data): (00,80,00), then (00,03,01).
- R3: When `mode_sel`=001 (serial-video), the next writes are (E3,07,01), (03,1F,prediv), (03,20,fbdiv[8]<<5), (04,FF,fbdiv[7:0]), (01,03,00), (01,04,04), (01,04,00), (20,01,00), (20,01,01), (00,7C,7C).
- R4: In the serial-video list, exactly RST_CYC cycles with `wr_valid` low follow acceptance of (01,04,04) and of (20,01,00). After every other accepted write that is not last, `wr_valid` is high again in the next cycle.
- R5: When `mode_sel`=010 (LVDS), the next writes after the prefix are (08,10,10), (E3,07,02), (03,1F,02), (03,20,00), (04,FF,1C), (EB,05,00), (E0,04,00), (E0,04,04), (E1,80,80), (EB,F8,F8).
- R6: In the LVDS list, exactly SETTLE_CYC idle cycles follow (EB,05,00) and exactly RST_CYC idle cycles follow (E0,04,00). All other steps run back to back.
- R7: The power-off list is (00,7C,00), (01,03,03), (00,03,02), (00,80,80), (EB,F8,00), (E1,80,00), (EB,05,05).
- R8: `busy` is high from the cycle after an accepted request until the last write is accepted. `done` is a single-cycle pulse in the cycle after the last write is accepted.
- R9: A power-on request with any `mode_sel` other than 001 or 010 gives a one-cycle `error` pulse in the next cycle. No write is issued and `busy` stays low.
- R10: Requests that arrive while `busy` is high have no effect on the running list.
- R11: When power-on and power-off are requested in the same idle cycle, the power-off list runs.
- R12: `rst` high at a clock edge leaves `busy`, `wr_valid`, `done` and `error` low after that edge. The next request then runs its full list from the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req | input | 1 | Power-on request (one cycle) |
| pwr_off_req | input | 1 | Power-off request (one cycle) |
| mode_sel | input | 3 | Output mode: 001 serial-video, 010 LVDS |
| prediv | input | 5 | PLL pre-divider for serial-video mode |
| fbdiv | input | 9 | PLL feedback divider for serial-video mode |
| wr_valid | output | 1 | Write request pending |
| wr_ack | input | 1 | Register port accepts the write |
| wr_addr | output | 8 | Group and offset of the register |
| wr_mask | output | 8 | Bits to be changed |
| wr_data | output | 8 | New value of the masked bits |
| busy | output | 1 | A list is running |
| done | output | 1 | List finished (one-cycle pulse) |
| error | output | 1 | Request rejected (one-cycle pulse) |

## Verification
A wrong step index or program select shows up at the port as a write with the wrong address, mask or data. A wrong list length shows up as a write count that does not match, or as `done` in the wrong cycle. A miscounted wait timer changes the number of idle cycles between two writes. That difference is measured the moment the following write appears, independent of how long the port takes to acknowledge. The acknowledge delay is randomised, so a step that advances without a handshake shows up as a missing or duplicated write in the captured list.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int PREDIV_W = 5;
    localparam int FBDIV_W  = 9;
    localparam int MODE_W   = 3;
    localparam int IDX_W    = 4;

    localparam logic [MODE_W-1:0] MODE_SERIAL = 3'b001;
    localparam logic [MODE_W-1:0] MODE_LVDS   = 3'b010;

    typedef enum logic [2:0] {
        GRP_ANALOG  = 3'd0,
        GRP_DIGITAL = 3'd1,
        GRP_LVDS    = 3'd7
    } grp_e;

    typedef enum logic [1:0] {
        PRG_SERIAL = 2'd0,
        PRG_LVDS   = 2'd1,
        PRG_OFF    = 2'd2
    } prog_e;

    typedef enum logic [1:0] {
        WT_NONE   = 2'd0,
        WT_RST    = 2'd1,
        WT_SETTLE = 2'd2
    } wait_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
        wait_e             wt;
        logic              last;
    } step_t;

    function automatic step_t mk_step(grp_e g, logic [4:0] off,
                                      logic [DATA_W-1:0] m, logic [DATA_W-1:0] d,
                                      wait_e w, logic last);
        step_t s;
        s.addr = {g, off};
        s.mask = m;
        s.data = d;
        s.wt   = w;
        s.last = last;
        return s;
    endfunction

endpackage

// File: rtl/pps_step_table.sv
module pps_step_table
    import pps_pkg::*;
(
    input  prog_e                prog,
    input  logic [IDX_W-1:0]     idx,
    input  logic [PREDIV_W-1:0]  prediv,
    input  logic [FBDIV_W-1:0]   fbdiv,
    output step_t                step
);
    logic [DATA_W-1:0] pd_field;
    logic [DATA_W-1:0] fb_hi_field;

    assign pd_field    = {{(DATA_W-PREDIV_W){1'b0}}, prediv};
    assign fb_hi_field = {2'b00, fbdiv[8], 5'b00000};

    always_comb begin
        step = mk_step(GRP_ANALOG, 5'h00, 8'h00, 8'h00, WT_NONE, 1'b1);
        if (prog == PRG_OFF) begin
            case (idx)
                4'd0: step = mk_step(GRP_ANALOG, 5'h00, 8'h7C, 8'h00, WT_NONE, 1'b0);
                4'd1: step = mk_step(GRP_ANALOG, 5'h01, 8'h03, 8'h03, WT_NONE, 1'b0);
                4'd2: step = mk_step(GRP_ANALOG, 5'h00, 8'h03, 8'h02, WT_NONE, 1'b0);
                4'd3: step = mk_step(GRP_ANALOG, 5'h00, 8'h80, 8'h80, WT_NONE, 1'b0);
                4'd4: step = mk_step(GRP_LVDS,   5'h0B, 8'hF8, 8'h00, WT_NONE, 1'b0);
                4'd5: step = mk_step(GRP_LVDS,   5'h01, 8'h80, 8'h00, WT_NONE, 1'b0);
                default: step = mk_step(GRP_LVDS, 5'h0B, 8'h05, 8'h05, WT_NONE, 1'b1);
            endcase
        end else if (idx == 4'd0) begin
            step = mk_step(GRP_ANALOG, 5'h00, 8'h80, 8'h00, WT_NONE, 1'b0);
        end else if (idx == 4'd1) begin
            step = mk_step(GRP_ANALOG, 5'h00, 8'h03, 8'h01, WT_NONE, 1'b0);
        end else if (prog == PRG_SERIAL) begin
            case (idx)
                4'd2:  step = mk_step(GRP_LVDS,    5'h03, 8'h07, 8'h01, WT_NONE, 1'b0);
                4'd3:  step = mk_step(GRP_ANALOG,  5'h03, 8'h1F, pd_field, WT_NONE, 1'b0);
                4'd4:  step = mk_step(GRP_ANALOG,  5'h03, 8'h20, fb_hi_field, WT_NONE, 1'b0);
                4'd5:  step = mk_step(GRP_ANALOG,  5'h04, 8'hFF, fbdiv[7:0], WT_NONE, 1'b0);
                4'd6:  step = mk_step(GRP_ANALOG,  5'h01, 8'h03, 8'h00, WT_NONE, 1'b0);
                4'd7:  step = mk_step(GRP_ANALOG,  5'h01, 8'h04, 8'h04, WT_RST,  1'b0);
                4'd8:  step = mk_step(GRP_ANALOG,  5'h01, 8'h04, 8'h00, WT_NONE, 1'b0);
                4'd9:  step = mk_step(GRP_DIGITAL, 5'h00, 8'h01, 8'h00, WT_RST,  1'b0);
                4'd10: step = mk_step(GRP_DIGITAL, 5'h00, 8'h01, 8'h01, WT_NONE, 1'b0);
                default: step = mk_step(GRP_ANALOG, 5'h00, 8'h7C, 8'h7C, WT_NONE, 1'b1);
            endcase
        end else begin
            case (idx)
                4'd2:  step = mk_step(GRP_ANALOG, 5'h08, 8'h10, 8'h10, WT_NONE,   1'b0);
                4'd3:  step = mk_step(GRP_LVDS,   5'h03, 8'h07, 8'h02, WT_NONE,   1'b0);
                4'd4:  step = mk_step(GRP_ANALOG, 5'h03, 8'h1F, 8'h02, WT_NONE,   1'b0);
                4'd5:  step = mk_step(GRP_ANALOG, 5'h03, 8'h20, 8'h00, WT_NONE,   1'b0);
                4'd6:  step = mk_step(GRP_ANALOG, 5'h04, 8'hFF, 8'h1C, WT_NONE,   1'b0);
                4'd7:  step = mk_step(GRP_LVDS,   5'h0B, 8'h05, 8'h00, WT_SETTLE, 1'b0);
                4'd8:  step = mk_step(GRP_LVDS,   5'h00, 8'h04, 8'h00, WT_RST,    1'b0);
                4'd9:  step = mk_step(GRP_LVDS,   5'h00, 8'h04, 8'h04, WT_NONE,   1'b0);
                4'd10: step = mk_step(GRP_LVDS,   5'h01, 8'h80, 8'h80, WT_NONE,   1'b0);
                default: step = mk_step(GRP_LVDS, 5'h0B, 8'hF8, 8'hF8, WT_NONE,   1'b1);
            endcase
        end
    end
endmodule

// File: rtl/pps_req_decode.sv
module pps_req_decode
    import pps_pkg::*;
(
    input  logic               on_req,
    input  logic               off_req,
    input  logic [MODE_W-1:0]  mode_sel,
    output logic               start,
    output logic               bad,
    output prog_e              prog
);
    always_comb begin
        start = 1'b0;
        bad   = 1'b0;
        prog  = PRG_OFF;
        if (off_req) begin
            start = 1'b1;
        end else if (on_req) begin
            if (mode_sel == MODE_SERIAL) begin
                start = 1'b1;
                prog  = PRG_SERIAL;
            end else if (mode_sel == MODE_LVDS) begin
                start = 1'b1;
                prog  = PRG_LVDS;
            end else begin
                bad = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pps_wait_timer.sv
module pps_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import pps_pkg::*;
#(
    parameter int RST_CYC    = 250,
    parameter int SETTLE_CYC = 5000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwr_on_req,
    input  logic                pwr_off_req,
    input  logic [2:0]          mode_sel,
    input  logic [4:0]          prediv,
    input  logic [8:0]          fbdiv,
    output logic                wr_valid,
    input  logic                wr_ack,
    output logic [7:0]          wr_addr,
    output logic [7:0]          wr_mask,
    output logic [7:0]          wr_data,
    output logic                busy,
    output logic                done,
    output logic                error
);
    localparam int MAX_WAIT = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
    localparam int CW       = $clog2(MAX_WAIT + 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

    state_e                 state;
    prog_e                  prog_q;
    logic [IDX_W-1:0]       idx_q;
    logic [PREDIV_W-1:0]    prediv_q;
    logic [FBDIV_W-1:0]     fbdiv_q;
    logic                   done_q;
    logic                   err_q;

    logic                   dec_start;
    logic                   dec_bad;
    prog_e                  dec_prog;
    step_t                  step;
    logic                   tmr_load;
    logic [CW-1:0]          tmr_val;
    logic                   tmr_expired;
    logic                   accept;

    pps_req_decode u_dec (
        .on_req   (pwr_on_req),
        .off_req  (pwr_off_req),
        .mode_sel (mode_sel),
        .start    (dec_start),
        .bad      (dec_bad),
        .prog     (dec_prog)
    );

    pps_step_table u_tbl (
        .prog   (prog_q),
        .idx    (idx_q),
        .prediv (prediv_q),
        .fbdiv  (fbdiv_q),
        .step   (step)
    );

    assign accept   = (state == S_ISSUE) && wr_ack;
    assign tmr_load = accept && !step.last && (step.wt != WT_NONE);
    assign tmr_val  = (step.wt == WT_SETTLE) ? CW'(SETTLE_CYC - 1) : CW'(RST_CYC - 1);

    pps_wait_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            prog_q   <= PRG_OFF;
            idx_q    <= '0;
            prediv_q <= '0;
            fbdiv_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (dec_start) begin
                        state    <= S_ISSUE;
                        prog_q   <= dec_prog;
                        idx_q    <= '0;
                        prediv_q <= prediv;
                        fbdiv_q  <= fbdiv;
                    end else if (dec_bad) begin
                        err_q <= 1'b1;
                    end
                end
                S_ISSUE: begin
                    if (accept) begin
                        if (step.last) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            if (step.wt != WT_NONE) state <= S_WAIT;
                        end
                    end
                end
                S_WAIT: begin
                    if (tmr_expired) state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign wr_valid = (state == S_ISSUE);
    assign wr_addr  = step.addr;
    assign wr_mask  = step.mask;
    assign wr_data  = step.data;
    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign error    = err_q;
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_valid,
    input logic       wr_ack,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_mask,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic       done,
    input logic       error
);
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_mask) && $stable(wr_data))); // R1

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_valid && wr_ack)); // R8

    AST_VALID_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy); // R8

    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (rst)
        error |-> (!busy && !wr_valid && !done)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy && !wr_valid && !done && !error)); // R12
endmodule

bind phy_pwr_seq pps_checker u_pps_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ack   (wr_ack),
    .wr_addr  (wr_addr),
    .wr_mask  (wr_mask),
    .wr_data  (wr_data),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/tb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_phy_pwr_seq;
    localparam int RSTC = 3;
    localparam int SETC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [4:0] prediv = '0;
    logic [8:0] fbdiv = '0;
    logic wr_valid, wr_ack, busy, done, error;
    logic [7:0] wr_addr, wr_mask, wr_data;

    always #2 clk = ~clk;

    phy_pwr_seq #(.RST_CYC(RSTC), .SETTLE_CYC(SETC)) dut (
        .clk(clk), .rst(rst), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
        .mode_sel(mode_sel), .prediv(prediv), .fbdiv(fbdiv),
        .wr_valid(wr_valid), .wr_ack(wr_ack), .wr_addr(wr_addr),
        .wr_mask(wr_mask), .wr_data(wr_data), .busy(busy), .done(done), .error(error)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ack_mode = 0;
    logic ack_r = 1'b0;
    assign wr_ack = ack_r;

    logic [23:0] t_w [0:15];
    int t_gap [0:15];
    int t_acc [0:15];
    int t_n = 0;
    int last_acc = 0;
    int start_c = 0;
    bit in_txn = 0;
    int done_cyc = -1;
    int err_cyc = -1;
    bit busy_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        logic nxt;
        nxt = (ack_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
        if (busy) busy_seen = 1;
        if (done && done_cyc < 0) done_cyc = cyc;
        if (error && err_cyc < 0) err_cyc = cyc;
        if (wr_valid && !in_txn) begin
            in_txn = 1;
            start_c = cyc;
        end
        if (wr_valid && nxt) begin
            if (t_n < 16) begin
                t_w[t_n]   = {wr_addr, wr_mask, wr_data};
                t_gap[t_n] = start_c - last_acc - 1;
                t_acc[t_n] = cyc;
            end
            t_n++;
            last_acc = cyc;
            in_txn = 0;
        end
        ack_r <= nxt;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected list: p 0 serial, 1 lvds, 2 off
    function automatic int exp_len(input int p);
        return (p == 2) ? 7 : 12;
    endfunction

    function automatic int exp_wait(input int p, input int i);
        if (p == 0 && (i == 7 || i == 9)) return RSTC;
        if (p == 1 && i == 7) return SETC;
        if (p == 1 && i == 8) return RSTC;
        return 0;
    endfunction

    function automatic logic [23:0] exp_w(input int p, input int i,
                                          input logic [4:0] pd, input logic [8:0] fd);
        if (p == 2) begin
            case (i)
                0: return 24'h007C00;
                1: return 24'h010303;
                2: return 24'h000302;
                3: return 24'h008080;
                4: return 24'hEBF800;
                5: return 24'hE18000;
                default: return 24'hEB0505;
            endcase
        end
        if (i == 0) return 24'h008000;
        if (i == 1) return 24'h000301;
        if (p == 0) begin
            case (i)
                2:  return 24'hE30701;
                3:  return {16'h031F, 3'b000, pd};
                4:  return {16'h0320, 2'b00, fd[8], 5'b00000};
                5:  return {16'h04FF, fd[7:0]};
                6:  return 24'h010300;
                7:  return 24'h010404;
                8:  return 24'h010400;
                9:  return 24'h200100;
                10: return 24'h200101;
                default: return 24'h007C7C;
            endcase
        end
        case (i)
            2:  return 24'h081010;
            3:  return 24'hE30702;
            4:  return 24'h031F02;
            5:  return 24'h032000;
            6:  return 24'h04FF1C;
            7:  return 24'hEB0500;
            8:  return 24'hE00400;
            9:  return 24'hE00404;
            10: return 24'hE18080;
            default: return 24'hEBF8F8;
        endcase
    endfunction

    function automatic string req_of(input int p, input int i);
        if (p == 2) return "R7";
        if (i < 2) return "R2";
        return (p == 0) ? "R3" : "R5";
    endfunction

    task automatic clear_cap();
        t_n = 0;
        done_cyc = -1;
        err_cyc = -1;
        busy_seen = 0;
    endtask

    // issue request, optionally poke more requests while busy after 'poke' cycles
    task automatic issue(input bit on, input bit off, input logic [2:0] m,
                         input logic [4:0] pd, input logic [8:0] fd, input int poke);
        clear_cap();
        @(negedge clk);
        pwr_on_req = on; pwr_off_req = off; mode_sel = m; prediv = pd; fbdiv = fd;
        @(negedge clk);
        pwr_on_req = 0; pwr_off_req = 0;
        prediv = ~pd; fbdiv = ~fd;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            pwr_on_req = 1; pwr_off_req = 1; mode_sel = 3'b010;
            @(negedge clk);
            pwr_on_req = 0; pwr_off_req = 0;
        end
        for (int k = 0; k < 600; k++) begin
            @(posedge clk);
            if (done_cyc >= 0 || err_cyc >= 0) break;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic verify(input int p, input logic [4:0] pd, input logic [8:0] fd);
        int n;
        chk(t_n == exp_len(p), (p == 2) ? "R7" : "R8", "write count", t_n, exp_len(p));
        n = (t_n < exp_len(p)) ? t_n : exp_len(p);
        if (n > 16) n = 16;
        for (int i = 0; i < n; i++) begin
            logic [23:0] e;
            e = exp_w(p, i, pd, fd);
            chk(t_w[i] == e, req_of(p, i), $sformatf("write %0d", i), t_w[i], e);
            if (i > 0) begin
                int eg;
                eg = exp_wait(p, i - 1);
                chk(t_gap[i] == eg, (p == 1) ? "R6" : "R4", $sformatf("gap before write %0d", i),
                    t_gap[i], eg);
            end
        end
        if (n > 0)
            chk(done_cyc == t_acc[n-1] + 1, "R8", "done cycle", done_cyc, t_acc[n-1] + 1);
        chk(err_cyc < 0, "R8", "no error on valid list", err_cyc, -1);
        chk(busy == 1'b0, "R8", "busy low after list", busy, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk(busy == 0 && wr_valid == 0 && done == 0 && error == 0, "R12", "reset state",
            {busy, wr_valid, done, error}, 0);
        @(negedge clk);
        rst = 0;
        repeat (2) @(negedge clk);

        // serial-video, always-ack and random acks, directed and random dividers
        ack_mode = 1;
        issue(1, 0, 3'b001, 5'h11, 9'h100, 0); verify(0, 5'h11, 9'h100);
        ack_mode = 0;
        issue(1, 0, 3'b001, 5'h1F, 9'h0FF, 0); verify(0, 5'h1F, 9'h0FF);
        for (int r = 0; r < 4; r++) begin
            logic [4:0] pd;
            logic [8:0] fd;
            pd = 5'($urandom);
            fd = 9'($urandom);
            issue(1, 0, 3'b001, pd, fd, 0); verify(0, pd, fd);
        end

        // LVDS
        issue(1, 0, 3'b010, 5'h03, 9'h033, 0); verify(1, 5'h03, 9'h033);
        ack_mode = 1;
        issue(1, 0, 3'b010, 5'h00, 9'h000, 0); verify(1, 5'h00, 9'h000);
        ack_mode = 0;

        // power-off
        issue(0, 1, 3'b001, 5'h00, 9'h000, 0); verify(2, 5'h00, 9'h000);

        // R11: both requests together -> power-off list
        issue(1, 1, 3'b001, 5'h05, 9'h055, 0); verify(2, 5'h05, 9'h055);

        // R10: requests while busy ignored
        issue(1, 0, 3'b001, 5'h0A, 9'h1AA, 5); verify(0, 5'h0A, 9'h1AA);
        chk(t_n == 12, "R10", "no extra writes after poke", t_n, 12);

        // R9: rejected modes
        for (int m = 0; m < 8; m++) begin
            if (m == 1 || m == 2) continue;
            issue(1, 0, 3'(m), 5'h01, 9'h001, 0);
            chk(t_n == 0, "R9", $sformatf("no writes mode %0d", m), t_n, 0);
            chk(!busy_seen, "R9", "busy stays low", busy_seen, 0);
            chk(err_cyc >= 0, "R9", "error pulse seen", err_cyc, 1);
        end

        // R12: synchronous reset mid-list, then full list again
        clear_cap();
        @(negedge clk);
        pwr_on_req = 1; mode_sel = 3'b001;
        @(negedge clk);
        pwr_on_req = 0;
        repeat (6) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(busy == 0 && wr_valid == 0, "R12", "idle after mid-list reset",
            {busy, wr_valid}, 0);
        rst = 0;
        @(negedge clk);
        issue(1, 0, 3'b010, 5'h00, 9'h000, 0); verify(1, 5'h00, 9'h000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule